// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the 8-bit execution unit of an accumulator-style microcontroller core. Each time the issue strobe is high, it takes the accumulator value, a source byte, the B register value, the current status byte and an operation code. It computes the new accumulator, the new B register and the new status byte, which holds carry, auxiliary carry, overflow and parity. The results are registered and appear one clock later with a one-cycle valid pulse. The registered status byte also selects one of four working-register banks, and the block outputs the base address of that bank.

The surrounding core handles instruction fetch, decoding, addressing and memory. It writes the three result bytes back into its own registers. Status bits that the ALU does not own go through unchanged: the general flag F0, the two bank-select bits and the user bit. The parity bit is always recomputed from the new accumulator, whatever operation ran.

Top module: `accalu_top`

## Requirements
- R1: After reset, accOut, bOut, pswOut and bankBase are 0 and resValid is 0. A cycle with opValid high loads new results on the next clock edge and raises resValid for exactly that one cycle. Without opValid, every result output holds its value.
- R2: The status byte layout is bit 7 CY, bit 6 AC, bit 5 F0, bit 4 RS1, bit 3 RS0, bit 2 OV, bit 1 user bit, bit 0 P. Bits 5, 4, 3 and 1 of pswOut are copied from pswIn for every operation.
- R3: ADD (code 0) gives A+src. ADDC (code 1) gives A+src+CY. CY is the carry out of bit 7, AC is the carry from bit 3 into bit 4, and OV is the carry into bit 7 XOR the carry out of bit 7. For example, 88h+93h gives 1Bh with CY=1 and AC=0, 38h+2Fh gives 67h with AC=1, and 9Ch+64h gives 00h with CY=1 and AC=1.
- R4: SUBB (code 2) gives A-src-CY. CY is the borrow out of bit 7, AC is the borrow out of the low nibble, and OV is the signed overflow (borrow into bit 7 XOR borrow out of bit 7).
- R5: INC (code 3) and DEC (code 4) add or subtract one from A. AND (5), OR (6) and XOR (7) combine A with src. CPL A (8) inverts A and CLR A (9) zeroes it. None of these operations changes CY, AC or OV.
- R6: RR (10) and RL (11) rotate A by one bit within 8 bits and leave CY unchanged. RRC (12) and RLC (13) rotate the 9-bit ring formed by A and CY. None of the rotates changes AC or OV.
- R7: MUL (14) forms the 16-bit product of A and B, with the low byte in accOut and the high byte in bOut. It clears CY and sets OV exactly when the product exceeds FFh. For example, 25h x 65h gives B=0Eh and A=99h.
- R8: DIV (15) puts A/B in accOut and A mod B in bOut, and it clears CY and OV. A zero divisor instead sets OV and clears CY, and accOut and bOut then carry no defined value.
- R9: CLR C (16) clears CY and CPL C (17) inverts CY. Both leave A, AC and OV unchanged.
- R10: pswOut bit 0 equals the XOR of the eight accOut bits after every operation.
- R11: bankBase is 00h, 08h, 10h or 18h for RS1:RS0 of pswOut equal to 00, 01, 10 or 11.
- R12: Codes 18 to 31 are unused. They return accOut=accIn, bOut=bIn and pswOut=pswIn with only P recomputed.
- R13: B passes through to bOut unchanged for every code other than 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Issue strobe for one operation |
| opCode | input | 5 | Operation code |
| accIn | input | 8 | Current accumulator |
| srcIn | input | 8 | Source operand byte |
| bIn | input | 8 | Current B register |
| pswIn | input | 8 | Current status byte |
| resValid | output | 1 | Results updated on this cycle |
| accOut | output | 8 | New accumulator |
| bOut | output | 8 | New B register |
| pswOut | output | 8 | New status byte |
| bankBase | output | 8 | Base address of the selected register bank |

## Verification
The corner cases targeted are the flag boundaries of the adder and subtractor. These are a nibble carry with no byte carry, a byte carry with no nibble carry, and a signed overflow at 7Fh+1 and 80h-1. A design that takes AC or OV from the wrong bit shows the wrong status byte on exactly those vectors. The through-carry rotates are run with CY both set and clear, which catches a design that swaps the direction or rotates only eight bits. A multiply whose product just fits in one byte and one that overflows check the OV rule. A divide by zero must flag OV without leaving CY set. The bench also checks that the bank-select and user bits survive every operation, since a design that rebuilt the status byte from scratch would lose them.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 5;

  // status byte bit positions
  localparam int unsigned PSW_CY  = 7;
  localparam int unsigned PSW_AC  = 6;
  localparam int unsigned PSW_F0  = 5;
  localparam int unsigned PSW_RS1 = 4;
  localparam int unsigned PSW_RS0 = 3;
  localparam int unsigned PSW_OV  = 2;
  localparam int unsigned PSW_UD  = 1;
  localparam int unsigned PSW_P   = 0;

  // operation codes
  localparam logic [OP_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OP_W-1:0] OP_ADDC = 5'd1;
  localparam logic [OP_W-1:0] OP_SUBB = 5'd2;
  localparam logic [OP_W-1:0] OP_INC  = 5'd3;
  localparam logic [OP_W-1:0] OP_DEC  = 5'd4;
  localparam logic [OP_W-1:0] OP_AND  = 5'd5;
  localparam logic [OP_W-1:0] OP_OR   = 5'd6;
  localparam logic [OP_W-1:0] OP_XOR  = 5'd7;
  localparam logic [OP_W-1:0] OP_CPLA = 5'd8;
  localparam logic [OP_W-1:0] OP_CLRA = 5'd9;
  localparam logic [OP_W-1:0] OP_RR   = 5'd10;
  localparam logic [OP_W-1:0] OP_RL   = 5'd11;
  localparam logic [OP_W-1:0] OP_RRC  = 5'd12;
  localparam logic [OP_W-1:0] OP_RLC  = 5'd13;
  localparam logic [OP_W-1:0] OP_MUL  = 5'd14;
  localparam logic [OP_W-1:0] OP_DIV  = 5'd15;
  localparam logic [OP_W-1:0] OP_CLRC = 5'd16;
  localparam logic [OP_W-1:0] OP_CPLC = 5'd17;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_ARITH,
    SEL_LOGIC,
    SEL_UNARY,
    SEL_ROT,
    SEL_MUL,
    SEL_DIV
  } resSel_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR
  } logicFn_e;

  typedef struct packed {
    resSel_e  sel;
    logic     sub;
    logic     useCy;
    logic     unitOperand;
    logicFn_e logicFn;
    logic     invA;
    logic     rotLeft;
    logic     rotThru;
    logic     updCy;
    logic     updAcOv;
    logic     clrCy;
    logic     cplCy;
  } aluStrobe_t;

endpackage

// File: rtl/accalu_ctrl.sv
module accalu_ctrl
  import accalu_pkg::*;
#(
  parameter int unsigned OPC_W = OP_W
) (
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    strobe.sel = SEL_HOLD;
    strobe.logicFn = LF_AND;
    case (opCode)
      OP_ADD: begin
        strobe.sel = SEL_ARITH;
        strobe.updCy = 1'b1;
        strobe.updAcOv = 1'b1;
      end
      OP_ADDC: begin
        strobe.sel = SEL_ARITH;
        strobe.useCy = 1'b1;
        strobe.updCy = 1'b1;
        strobe.updAcOv = 1'b1;
      end
      OP_SUBB: begin
        strobe.sel = SEL_ARITH;
        strobe.sub = 1'b1;
        strobe.useCy = 1'b1;
        strobe.updCy = 1'b1;
        strobe.updAcOv = 1'b1;
      end
      OP_INC: begin
        strobe.sel = SEL_ARITH;
        strobe.unitOperand = 1'b1;
      end
      OP_DEC: begin
        strobe.sel = SEL_ARITH;
        strobe.sub = 1'b1;
        strobe.unitOperand = 1'b1;
      end
      OP_AND: begin
        strobe.sel = SEL_LOGIC;
        strobe.logicFn = LF_AND;
      end
      OP_OR: begin
        strobe.sel = SEL_LOGIC;
        strobe.logicFn = LF_OR;
      end
      OP_XOR: begin
        strobe.sel = SEL_LOGIC;
        strobe.logicFn = LF_XOR;
      end
      OP_CPLA: begin
        strobe.sel = SEL_UNARY;
        strobe.invA = 1'b1;
      end
      OP_CLRA: strobe.sel = SEL_UNARY;
      OP_RR:   strobe.sel = SEL_ROT;
      OP_RL: begin
        strobe.sel = SEL_ROT;
        strobe.rotLeft = 1'b1;
      end
      OP_RRC: begin
        strobe.sel = SEL_ROT;
        strobe.rotThru = 1'b1;
        strobe.updCy = 1'b1;
      end
      OP_RLC: begin
        strobe.sel = SEL_ROT;
        strobe.rotLeft = 1'b1;
        strobe.rotThru = 1'b1;
        strobe.updCy = 1'b1;
      end
      OP_MUL: begin
        strobe.sel = SEL_MUL;
        strobe.updCy = 1'b1;
      end
      OP_DIV: begin
        strobe.sel = SEL_DIV;
        strobe.updCy = 1'b1;
      end
      OP_CLRC: strobe.clrCy = 1'b1;
      OP_CPLC: strobe.cplCy = 1'b1;
      default: strobe.sel = SEL_HOLD;
    endcase
  end

endmodule

// File: rtl/accalu_dp.sv
module accalu_dp
  import accalu_pkg::*;
#(
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned AUX_BIT = 4
) (
  input  aluStrobe_t    strobe,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] srcIn,
  input  logic [DW-1:0] bIn,
  input  logic          cyIn,
  input  logic          acIn,
  input  logic          ovIn,
  output logic [DW-1:0] accNext,
  output logic [DW-1:0] bNext,
  output logic          cyNext,
  output logic          acNext,
  output logic          ovNext
);

  localparam int unsigned PW = 2 * DW;

  logic [DW-1:0] opd;
  logic          cin;
  logic [DW:0]   sumFull, difFull;
  logic [AUX_BIT:0] sumLow, difLow;
  logic [DW-1:0] sumMid, difMid;
  logic [DW-1:0] arithRes;
  logic          arithCy, arithAc, arithOv;
  logic [PW-1:0] prod;
  logic [DW-1:0] quot, remd;
  logic          divZero;

  assign opd = strobe.unitOperand ? DW'(1) : srcIn;
  assign cin = strobe.useCy & cyIn;

  // full, nibble and seven-bit partial sums give carry-out, aux carry and carry into the sign bit
  assign sumFull = {1'b0, accIn} + {1'b0, opd} + {{DW{1'b0}}, cin};
  assign difFull = {1'b0, accIn} - {1'b0, opd} - {{DW{1'b0}}, cin};
  assign sumLow  = {1'b0, accIn[AUX_BIT-1:0]} + {1'b0, opd[AUX_BIT-1:0]} + {{AUX_BIT{1'b0}}, cin};
  assign difLow  = {1'b0, accIn[AUX_BIT-1:0]} - {1'b0, opd[AUX_BIT-1:0]} - {{AUX_BIT{1'b0}}, cin};
  assign sumMid  = {1'b0, accIn[DW-2:0]} + {1'b0, opd[DW-2:0]} + {{(DW-1){1'b0}}, cin};
  assign difMid  = {1'b0, accIn[DW-2:0]} - {1'b0, opd[DW-2:0]} - {{(DW-1){1'b0}}, cin};

  always_comb begin
    if (strobe.sub) begin
      arithRes = difFull[DW-1:0];
      arithCy  = difFull[DW];
      arithAc  = difLow[AUX_BIT];
      arithOv  = difMid[DW-1] ^ difFull[DW];
    end else begin
      arithRes = sumFull[DW-1:0];
      arithCy  = sumFull[DW];
      arithAc  = sumLow[AUX_BIT];
      arithOv  = sumMid[DW-1] ^ sumFull[DW];
    end
  end

  assign prod    = {{DW{1'b0}}, accIn} * {{DW{1'b0}}, bIn};
  assign divZero = (bIn == '0);
  assign quot    = divZero ? accIn : accIn / bIn;
  assign remd    = divZero ? bIn : accIn % bIn;

  always_comb begin
    accNext = accIn;
    bNext   = bIn;
    cyNext  = cyIn;
    acNext  = acIn;
    ovNext  = ovIn;
    unique case (strobe.sel)
      SEL_ARITH: begin
        accNext = arithRes;
        if (strobe.updCy) cyNext = arithCy;
        if (strobe.updAcOv) begin
          acNext = arithAc;
          ovNext = arithOv;
        end
      end
      SEL_LOGIC: begin
        unique case (strobe.logicFn)
          LF_OR:   accNext = accIn | srcIn;
          LF_XOR:  accNext = accIn ^ srcIn;
          default: accNext = accIn & srcIn;
        endcase
      end
      SEL_UNARY: accNext = strobe.invA ? ~accIn : '0;
      SEL_ROT: begin
        if (strobe.rotLeft) begin
          accNext = {accIn[DW-2:0], strobe.rotThru ? cyIn : accIn[DW-1]};
          if (strobe.updCy) cyNext = accIn[DW-1];
        end else begin
          accNext = {strobe.rotThru ? cyIn : accIn[0], accIn[DW-1:1]};
          if (strobe.updCy) cyNext = accIn[0];
        end
      end
      SEL_MUL: begin
        accNext = prod[DW-1:0];
        bNext   = prod[PW-1:DW];
        cyNext  = 1'b0;
        ovNext  = |prod[PW-1:DW];
      end
      SEL_DIV: begin
        accNext = quot;
        bNext   = remd;
        cyNext  = 1'b0;
        ovNext  = divZero;
      end
      default: begin
        if (strobe.clrCy) cyNext = 1'b0;
        else if (strobe.cplCy) cyNext = ~cyIn;
      end
    endcase
  end

endmodule

// File: rtl/accalu_top.sv
module accalu_top
  import accalu_pkg::*;
#(
  parameter int unsigned DW        = DATA_W,
  parameter int unsigned OPC_W     = OP_W,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     srcIn,
  input  logic [DW-1:0]     bIn,
  input  logic [7:0]        pswIn,
  output logic              resValid,
  output logic [DW-1:0]     accOut,
  output logic [DW-1:0]     bOut,
  output logic [7:0]        pswOut,
  output logic [ADDR_W-1:0] bankBase
);

  aluStrobe_t    strobe;
  logic [DW-1:0] accNext, bNext;
  logic          cyNext, acNext, ovNext;
  logic [7:0]    pswNext;

  accalu_ctrl #(.OPC_W(OPC_W)) uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  accalu_dp #(.DW(DW), .AUX_BIT(4)) uDp (
    .strobe  (strobe),
    .accIn   (accIn),
    .srcIn   (srcIn),
    .bIn     (bIn),
    .cyIn    (pswIn[PSW_CY]),
    .acIn    (pswIn[PSW_AC]),
    .ovIn    (pswIn[PSW_OV]),
    .accNext (accNext),
    .bNext   (bNext),
    .cyNext  (cyNext),
    .acNext  (acNext),
    .ovNext  (ovNext)
  );

  always_comb begin
    pswNext         = pswIn;
    pswNext[PSW_CY] = cyNext;
    pswNext[PSW_AC] = acNext;
    pswNext[PSW_OV] = ovNext;
    pswNext[PSW_P]  = ^accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      accOut   <= '0;
      bOut     <= '0;
      pswOut   <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        accOut <= accNext;
        bOut   <= bNext;
        pswOut <= pswNext;
      end
    end
  end

  assign bankBase = ADDR_W'({pswOut[PSW_RS1], pswOut[PSW_RS0]}) * ADDR_W'(BANK_REGS);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> ($stable(accOut) && $stable(bOut) && $stable(pswOut))); // R1

  AST_PSW_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid) |-> ({pswOut[PSW_F0], pswOut[PSW_RS1], pswOut[PSW_RS0], pswOut[PSW_UD]} ==
                        $past({pswIn[PSW_F0], pswIn[PSW_RS1], pswIn[PSW_RS0], pswIn[PSW_UD]}))); // R2

  AST_PLAIN_OPS_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) >= OP_INC) && ($past(opCode) <= OP_CLRA)) |->
      ({pswOut[PSW_CY], pswOut[PSW_AC], pswOut[PSW_OV]} ==
       $past({pswIn[PSW_CY], pswIn[PSW_AC], pswIn[PSW_OV]}))); // R5

  AST_ROT_KEEP_AC_OV: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) >= OP_RR) && ($past(opCode) <= OP_RLC)) |->
      ({pswOut[PSW_AC], pswOut[PSW_OV]} == $past({pswIn[PSW_AC], pswIn[PSW_OV]}))); // R6

  AST_MUL_CLEARS_CY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) == OP_MUL)) |-> !pswOut[PSW_CY]); // R7

  AST_DIV_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) == OP_DIV) && ($past(bIn) == '0)) |->
      (pswOut[PSW_OV] && !pswOut[PSW_CY])); // R8

  AST_CLRC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) == OP_CLRC)) |-> (!pswOut[PSW_CY] && (accOut == $past(accIn)))); // R9

  AST_PARITY_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (pswOut[PSW_P] == ^accOut)); // R10

  AST_UNUSED_CODE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) > OP_CPLC)) |->
      ((accOut == $past(accIn)) && (bOut == $past(bIn)) && (pswOut[7:1] == $past(pswIn[7:1])))); // R12

  AST_B_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opValid) && ($past(opCode) != OP_MUL) && ($past(opCode) != OP_DIV)) |->
      (bOut == $past(bIn))); // R13

endmodule

// File: tb/tb_accalu_top.sv
module tb_accalu_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0, srcIn = '0, bIn = '0, pswIn = '0;
  logic       resValid;
  logic [7:0] accOut, bOut, pswOut, bankBase;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  accalu_top dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .srcIn(srcIn), .bIn(bIn), .pswIn(pswIn),
    .resValid(resValid), .accOut(accOut), .bOut(bOut), .pswOut(pswOut),
    .bankBase(bankBase)
  );

  // {op, acc, src, b, psw, expAcc, expB, expPsw}
  localparam int NV = 28;
  localparam logic [60:0] VEC [NV] = '{
    {5'd0,  8'h88, 8'h93, 8'hA5, 8'h00, 8'h1B, 8'hA5, 8'h84},
    {5'd0,  8'h38, 8'h2F, 8'hA5, 8'h00, 8'h67, 8'hA5, 8'h41},
    {5'd0,  8'h9C, 8'h64, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hC0},
    {5'd1,  8'h7F, 8'h00, 8'hA5, 8'h80, 8'h80, 8'hA5, 8'h45},
    {5'd0,  8'h01, 8'h01, 8'h3C, 8'h3A, 8'h02, 8'h3C, 8'h3B},
    {5'd2,  8'h10, 8'h01, 8'hA5, 8'h80, 8'h0E, 8'hA5, 8'h41},
    {5'd2,  8'h00, 8'h01, 8'hA5, 8'h00, 8'hFF, 8'hA5, 8'hC0},
    {5'd2,  8'h80, 8'h01, 8'hA5, 8'h00, 8'h7F, 8'hA5, 8'h45},
    {5'd3,  8'hFF, 8'h77, 8'hA5, 8'h44, 8'h00, 8'hA5, 8'h44},
    {5'd4,  8'h00, 8'h77, 8'hA5, 8'h80, 8'hFF, 8'hA5, 8'h80},
    {5'd5,  8'h5A, 8'h0F, 8'hA5, 8'h18, 8'h0A, 8'hA5, 8'h18},
    {5'd6,  8'h50, 8'h0A, 8'hA5, 8'h20, 8'h5A, 8'hA5, 8'h20},
    {5'd7,  8'h55, 8'hFE, 8'hA5, 8'h02, 8'hAB, 8'hA5, 8'h03},
    {5'd8,  8'h55, 8'h00, 8'hA5, 8'h80, 8'hAA, 8'hA5, 8'h80},
    {5'd9,  8'h37, 8'h00, 8'hA5, 8'hC4, 8'h00, 8'hA5, 8'hC4},
    {5'd10, 8'h81, 8'h00, 8'hA5, 8'h00, 8'hC0, 8'hA5, 8'h00},
    {5'd11, 8'h81, 8'h00, 8'hA5, 8'h80, 8'h03, 8'hA5, 8'h80},
    {5'd12, 8'h01, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'h80},
    {5'd13, 8'h80, 8'h00, 8'hA5, 8'h80, 8'h01, 8'hA5, 8'h81},
    {5'd12, 8'h00, 8'h00, 8'hA5, 8'h80, 8'h80, 8'hA5, 8'h01},
    {5'd14, 8'h25, 8'h00, 8'h65, 8'h80, 8'h99, 8'h0E, 8'h04},
    {5'd14, 8'h10, 8'h00, 8'h0F, 8'hC4, 8'hF0, 8'h00, 8'h40},
    {5'd15, 8'h19, 8'h00, 8'h0A, 8'h84, 8'h02, 8'h05, 8'h01},
    {5'd15, 8'hFF, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h00, 8'h00},
    {5'd16, 8'h3C, 8'h00, 8'hA5, 8'hC4, 8'h3C, 8'hA5, 8'h44},
    {5'd17, 8'h01, 8'h00, 8'hA5, 8'h00, 8'h01, 8'hA5, 8'h81},
    {5'd17, 8'h00, 8'h00, 8'hA5, 8'h80, 8'h00, 8'hA5, 8'h00},
    {5'd31, 8'h07, 8'h00, 8'h33, 8'h5A, 8'h07, 8'h33, 8'h5B}
  };

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:             return "R3";
      5'd2:                   return "R4";
      5'd3, 5'd4, 5'd5, 5'd6,
      5'd7, 5'd8, 5'd9:       return "R5";
      5'd10, 5'd11, 5'd12, 5'd13: return "R6";
      5'd14:                  return "R7";
      5'd15:                  return "R8";
      5'd16, 5'd17:           return "R9";
      default:                return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [7:0] a, input logic [7:0] s,
                       input logic [7:0] b, input logic [7:0] p);
    @(negedge clk);
    opCode = op; accIn = a; srcIn = s; bIn = b; pswIn = p; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "resValid in reset", {7'd0, resValid}, 8'h00);
    check("R1", "accOut in reset", accOut, 8'h00);
    check("R1", "pswOut in reset", pswOut, 8'h00);
    check("R11", "bankBase in reset", bankBase, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      v = VEC[i];
      issue(v[60:56], v[55:48], v[47:40], v[39:32], v[31:24]);
      check(reqOf(v[60:56]), "accOut", accOut, v[23:16]);
      check("R13", "bOut", bOut, v[15:8]);
      check("R2", "pswOut", pswOut, v[7:0]);
      check("R10", "parity", {7'd0, pswOut[0]}, {7'd0, ^v[23:16]});
    end

    // R1: valid pulse width and hold when idle
    issue(5'd0, 8'h11, 8'h22, 8'h44, 8'h00);
    check("R1", "resValid after issue", {7'd0, resValid}, 8'h01);
    accIn = 8'hEE; srcIn = 8'h01; bIn = 8'h99; pswIn = 8'hFF; opCode = 5'd9;
    @(negedge clk);
    check("R1", "resValid next cycle", {7'd0, resValid}, 8'h00);
    repeat (3) @(negedge clk);
    check("R1", "accOut held", accOut, 8'h33);
    check("R1", "bOut held", bOut, 8'h44);
    check("R1", "pswOut held", pswOut, 8'h00);

    // R8: divide by zero sets OV and clears CY
    issue(5'd15, 8'h44, 8'h00, 8'h00, 8'h80);
    check("R8", "div zero OV", {7'd0, pswOut[2]}, 8'h01);
    check("R8", "div zero CY", {7'd0, pswOut[7]}, 8'h00);

    // R11: bank base decode
    issue(5'd16, 8'h00, 8'h00, 8'h00, 8'h08);
    check("R11", "bank 1 base", bankBase, 8'h08);
    issue(5'd16, 8'h00, 8'h00, 8'h00, 8'h10);
    check("R11", "bank 2 base", bankBase, 8'h10);
    issue(5'd16, 8'h00, 8'h00, 8'h00, 8'h18);
    check("R11", "bank 3 base", bankBase, 8'h18);
    issue(5'd16, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R11", "bank 0 base", bankBase, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule